// File: doc/BRIEF.md
# Multi-port GPIO controller with pin interrupts

This block is a register-mapped general-purpose I/O controller with up to four ports of `PORT_W` pins each. Each port has an output-value register and a drive-enable register, so a pin is either an input or is driven from its output register. Each port can also read back its pins through a separate register, which returns the level seen at the pin after a two-flop synchroniser and not the value that software wrote.

The first port (port 0) also has per-pin interrupt logic. Each pin has an enable, a mask, a level-or-edge select and a polarity select. A pin can also have a debounce filter. Edge events stay latched until software writes a one to the clear register at that pin's bit. Level events follow the pin. One control bit chooses whether interrupt detection samples the first or the second synchroniser stage. The combined `irq_o` line is the OR of all unmasked, enabled interrupt sources. Software reaches every register through a single-cycle 32-bit read/write port: writes take effect at the clock edge and read data is combinational.

Each port-0 pin has a debounce filter, which is a two-state machine. In state STABLE the filtered value equals the input. The transition STABLE→SETTLE happens when the input differs from the filtered value. In SETTLE the filter counts slow ticks. The transition SETTLE→STABLE with no change happens if the input returns to the filtered value. The transition SETTLE→STABLE with an update happens when the input has stayed different for `DB_TICKS` ticks.

Top module: `gpio_multiport`

## Requirements
- R1: After reset all registers read 0, except the sync-select register at 0x60, which reads 1. `pin_oe`, `pin_out` and `irq_o` are 0, so every pin is an input and every interrupt is disabled and unmasked.
- R2: Port p has its output register at byte offset 12·p and its drive-enable register at 12·p+4. Only the low `PORT_W` bits are kept and read back. `pin_out` slice p equals the output register. `pin_oe` slice p equals the drive-enable register, where 1 means driven and 0 means input.
- R3: The pin register of port p at 0x50+4·p returns `pin_in` slice p as it was two clocks earlier. It does not depend on the output register.
- R4: In level mode (type bit 0 at 0x38), a port-0 pin is pending while its qualified input equals its polarity bit (0x3C: 1 means high, 0 means low). It stops being pending as soon as the input leaves that level. Writing to the clear register does not end a level event.
- R5: In edge mode (type bit 1), a rising edge (polarity 1) or a falling edge (polarity 0) of the qualified input latches the pin as pending. The opposite edge has no effect. The latch holds until a 1 is written at that bit of 0x4C, and writing 0 bits leaves it set.
- R6: A pin whose enable bit (0x30) is 0 is never pending, and clearing its enable bit drops any latched edge.
- R7: A set mask bit (0x34) removes the pin from the status register (0x40) and from `irq_o`. The raw register (0x44) still shows the pin as pending.
- R8: `irq_o` is 1 exactly when the status register is nonzero.
- R9: With the debounce bit (0x48) set, the pin's qualified input changes only after the detected input has differed from it for `DB_TICKS` consecutive ticks, where one tick occurs every `DB_DIV` clocks. A pulse of 2 clocks never reaches the interrupt logic.
- R10: With bit 0 of 0x60 at 1, detection uses the second synchroniser stage, so a level event shows on `irq_o` two clocks after the pin changes. With it at 0, detection uses the first stage and the event shows one clock after the pin changes.
- R11: The pins of ports 1 and up never affect `irq_o`, the status register or the raw register.
- R12: Offsets that map to no register (for example 0x08 and 0x2C) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the read |
| pin_in | input | NUM_PORTS·PORT_W | Pin levels from the pads |
| pin_out | output | NUM_PORTS·PORT_W | Output values towards the pads |
| pin_oe | output | NUM_PORTS·PORT_W | Per-pin drive enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stale edge latch shows as a status bit that survives its clear write or appears on the wrong edge. It is visible at the very next read, because the latch updates at the edge after the event. A debounce state machine stuck in SETTLE or counting wrongly lets a 2-clock glitch through, or delays a real change past the expected window of about `DB_TICKS`·`DB_DIV` clocks. Either fault shows on `irq_o` within a few tens of clocks. A fault in the synchroniser path or in stage selection shifts the event on `irq_o` by one clock against the pin, so the bench samples one and two clocks after each change.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    // Port group layout: output and drive-enable words, one spare word
    localparam int PORT_STRIDE = 12;

    // Port-0 interrupt and control registers
    localparam int OFF_IRQ_EN   = 'h30;
    localparam int OFF_IRQ_MASK = 'h34;
    localparam int OFF_IRQ_TYPE = 'h38;
    localparam int OFF_IRQ_POL  = 'h3C;
    localparam int OFF_STATUS   = 'h40;
    localparam int OFF_RAW      = 'h44;
    localparam int OFF_DB_EN    = 'h48;
    localparam int OFF_CLEAR    = 'h4C;
    localparam int OFF_PIN_BASE = 'h50;
    localparam int OFF_SYNC_SEL = 'h60;

    function automatic int port_out_off(input int p);
        return PORT_STRIDE * p;
    endfunction

    function automatic int port_oe_off(input int p);
        return PORT_STRIDE * p + 4;
    endfunction

    function automatic int port_pin_off(input int p);
        return OFF_PIN_BASE + 4 * p;
    endfunction

    typedef enum logic {
        DB_STABLE = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;

endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] s1,
    output logic [W-1:0] s2
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= '0;
            s2    <= '0;
            age_q <= 2'd0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (age_q != 2'd2) begin
                age_q <= age_q + 2'd1;
            end
        end
    end

    // R3
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (s2 == $past(din, 2)));

endmodule

// File: rtl/gpio_mp_debounce.sv
module gpio_mp_debounce
    import gpio_mp_pkg::*;
#(
    parameter int TICKS = 4,
    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout
);

    db_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            val_q, val_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STABLE;
            cnt_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            val_q   <= val_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        val_d   = val_q;
        unique case (state_q)
            DB_STABLE: begin
                if (din != val_q) begin
                    state_d = DB_SETTLE;
                    cnt_d   = '0;
                end
            end
            DB_SETTLE: begin
                if (din == val_q) begin
                    state_d = DB_STABLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q == CW'(TICKS - 1)) begin
                        val_d   = din;
                        state_d = DB_STABLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = DB_STABLE;
        endcase
    end

    always_comb begin
        dout = val_q;
    end

    // R9
    filt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q != $past(val_q)) |-> ($past(state_q) == DB_SETTLE && $past(tick)));

endmodule

// File: rtl/gpio_mp_irq.sv
module gpio_mp_irq #(
    parameter int W        = 8,
    parameter int DB_TICKS = 4,
    parameter int DB_DIV   = 4,
    localparam int DIV_W   = (DB_DIV < 2) ? 1 : $clog2(DB_DIV)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s1_i,
    input  logic [W-1:0] s2_i,
    input  logic         sync_sel_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] type_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] db_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] status_o,
    output logic         irq_o
);

    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic [W-1:0]     det, filt, qual, prev_q, lat_q, hit, lvl;

    // Slow tick for the debounce filters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIV_W'(DB_DIV - 1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
    assign tick = (div_q == DIV_W'(DB_DIV - 1));

    assign det = sync_sel_i ? s2_i : s1_i;

    for (genvar i = 0; i < W; i++) begin : g_db
        gpio_mp_debounce #(.TICKS(DB_TICKS)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .din  (det[i]),
            .dout (filt[i])
        );
    end

    assign qual = (db_i & filt) | (~db_i & det);
    assign hit  = (pol_i & qual & ~prev_q) | (~pol_i & ~qual & prev_q);
    assign lvl  = ~(qual ^ pol_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            lat_q  <= '0;
        end else begin
            prev_q <= qual;
            lat_q  <= en_i & ((lat_q & ~clr_i) | (type_i & hit));
        end
    end

    assign raw_o    = en_i & ((~type_i & lvl) | (type_i & lat_q));
    assign status_o = raw_o & ~mask_i;
    assign irq_o    = |status_o;

    // R6
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_i != '0));

    // R7
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en_i & ~mask_i) != '0));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lat_q) & ~lat_q & $past(en_i) & ~$past(clr_i)) == '0));

endmodule

// File: rtl/gpio_multiport.sv
module gpio_multiport
    import gpio_mp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int DB_TICKS  = 4,
    parameter int DB_DIV    = 4,
    localparam int NPINS    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_o
);

    logic              wr_en;
    logic [PORT_W-1:0] wd;
    logic [PORT_W-1:0] out_q [NUM_PORTS];
    logic [PORT_W-1:0] oe_q  [NUM_PORTS];
    logic [PORT_W-1:0] en_q, mask_q, type_q, pol_q, db_q, clr;
    logic              sync_q;
    logic [NPINS-1:0]  s1_all, s2_all;
    logic [PORT_W-1:0] raw, status;

    assign wr_en = bus_sel & bus_wr;
    assign wd    = bus_wdata[PORT_W-1:0];

    function automatic logic hit_wr(input int off);
        return wr_en && (bus_addr == ADDR_W'(off));
    endfunction

    // Per-port output and drive-enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                out_q[p] <= '0;
                oe_q[p]  <= '0;
            end
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (hit_wr(port_out_off(p))) out_q[p] <= wd;
                if (hit_wr(port_oe_off(p)))  oe_q[p]  <= wd;
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pins
        assign pin_out[p*PORT_W +: PORT_W] = out_q[p];
        assign pin_oe[p*PORT_W +: PORT_W]  = oe_q[p];
    end

    // Port-0 interrupt configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
            db_q   <= '0;
            sync_q <= 1'b1;
        end else begin
            if (hit_wr(OFF_IRQ_EN))   en_q   <= wd;
            if (hit_wr(OFF_IRQ_MASK)) mask_q <= wd;
            if (hit_wr(OFF_IRQ_TYPE)) type_q <= wd;
            if (hit_wr(OFF_IRQ_POL))  pol_q  <= wd;
            if (hit_wr(OFF_DB_EN))    db_q   <= wd;
            if (hit_wr(OFF_SYNC_SEL)) sync_q <= wd[0];
        end
    end

    assign clr = hit_wr(OFF_CLEAR) ? wd : '0;

    gpio_mp_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .s1   (s1_all),
        .s2   (s2_all)
    );

    gpio_mp_irq #(
        .W       (PORT_W),
        .DB_TICKS(DB_TICKS),
        .DB_DIV  (DB_DIV)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_i      (s1_all[PORT_W-1:0]),
        .s2_i      (s2_all[PORT_W-1:0]),
        .sync_sel_i(sync_q),
        .en_i      (en_q),
        .mask_i    (mask_q),
        .type_i    (type_q),
        .pol_i     (pol_q),
        .db_i      (db_q),
        .clr_i     (clr),
        .raw_o     (raw),
        .status_o  (status),
        .irq_o     (irq_o)
    );

    if (NUM_PORTS > 1) begin : g_s1_sink
        logic unused_s1;
        assign unused_s1 = ^s1_all[NPINS-1:PORT_W];
    end
    if (DATA_W > PORT_W) begin : g_wd_sink
        logic unused_wd;
        assign unused_wd = ^bus_wdata[DATA_W-1:PORT_W];
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_W'(port_out_off(p))) bus_rdata[PORT_W-1:0] = out_q[p];
                if (bus_addr == ADDR_W'(port_oe_off(p)))  bus_rdata[PORT_W-1:0] = oe_q[p];
                if (bus_addr == ADDR_W'(port_pin_off(p)))
                    bus_rdata[PORT_W-1:0] = s2_all[p*PORT_W +: PORT_W];
            end
            case (bus_addr)
                ADDR_W'(OFF_IRQ_EN):   bus_rdata[PORT_W-1:0] = en_q;
                ADDR_W'(OFF_IRQ_MASK): bus_rdata[PORT_W-1:0] = mask_q;
                ADDR_W'(OFF_IRQ_TYPE): bus_rdata[PORT_W-1:0] = type_q;
                ADDR_W'(OFF_IRQ_POL):  bus_rdata[PORT_W-1:0] = pol_q;
                ADDR_W'(OFF_STATUS):   bus_rdata[PORT_W-1:0] = status;
                ADDR_W'(OFF_RAW):      bus_rdata[PORT_W-1:0] = raw;
                ADDR_W'(OFF_DB_EN):    bus_rdata[PORT_W-1:0] = db_q;
                ADDR_W'(OFF_SYNC_SEL): bus_rdata[0]          = sync_q;
                default: ;
            endcase
        end
    end

    // R8
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (status != '0));

endmodule

// File: tb/gpio_multiport_tb.sv
`timescale 1ns/1ps
module gpio_multiport_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pin_in, pin_out, pin_oe;
    logic        irq_o;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    logic [31:0] m_out = '0;
    logic [31:0] m_oe  = '0;

    always #2.5 clk = ~clk;

    gpio_multiport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    function automatic logic [7:0] lvl_raw(input logic [7:0] en, input logic [7:0] pol,
                                            input logic [7:0] pins);
        return en & ~(pins ^ pol);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic cfg(input logic [7:0] en, input logic [7:0] typ, input logic [7:0] pol,
                       input logic [7:0] msk, input logic [7:0] db);
        wr(8'h30, 32'h0);
        wr(8'h34, {24'h0, msk});
        wr(8'h38, {24'h0, typ});
        wr(8'h3C, {24'h0, pol});
        wr(8'h48, {24'h0, db});
        wr(8'h30, {24'h0, en});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pin_in = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        for (int p = 0; p < 4; p++) begin
            rchk("R1 out reg", 8'(12*p), 32'h0);
            rchk("R1 oe reg", 8'(12*p+4), 32'h0);
        end
        for (int a = 'h30; a <= 'h4C; a += 4) rchk("R1 irq regs", 8'(a), 32'h0);
        rchk("R1 sync sel", 8'h60, 32'h1);

        // R2 directed
        wr(8'h0C, 32'h0000_00A5); m_out[15:8] = 8'hA5;
        wr(8'h10, 32'h0000_00F0); m_oe[15:8]  = 8'hF0;
        chk("R2 pin_out", pin_out, m_out);
        chk("R2 pin_oe", pin_oe, m_oe);
        wr(8'h18, 32'hFFFF_FF3C); m_out[23:16] = 8'h3C;
        rchk("R2 width", 8'h18, 32'h3C);

        // R12 unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rchk("R12 gap read", 8'h08, 32'h0);
        rchk("R12 tail read", 8'h2C, 32'h0);
        chk("R12 out unchanged", pin_out, m_out);
        chk("R12 oe unchanged", pin_oe, m_oe);

        // R2 random
        for (int k = 0; k < 40; k++) begin
            int p;
            logic [31:0] d;
            p = int'($urandom % 4);
            d = $urandom;
            if ($urandom % 2 == 0) begin
                wr(8'(12*p), d); m_out[p*8 +: 8] = d[7:0];
            end else begin
                wr(8'(12*p+4), d); m_oe[p*8 +: 8] = d[7:0];
            end
            chk("R2 rand out", pin_out, m_out);
            chk("R2 rand oe", pin_oe, m_oe);
            rchk("R2 rand readback out", 8'(12*p), {24'h0, m_out[p*8 +: 8]});
        end

        // R3 latency
        wr(8'h00, 32'hFF); m_out[7:0] = 8'hFF;
        pin_in = '0;
        cyc(3);
        pin_in = 32'h0000_00C3;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h50;
        #1 chk("R3 one clock", bus_rdata, 32'h0);
        @(negedge clk);
        #1 chk("R3 two clocks", bus_rdata, 32'hC3);
        bus_sel = 1'b0;

        // R3 random
        for (int k = 0; k < 20; k++) begin
            logic [31:0] v;
            v = $urandom;
            pin_in = v;
            cyc(2);
            for (int p = 0; p < 4; p++) rchk("R3 pin reg", 8'(8'h50 + 4*p), {24'h0, v[p*8 +: 8]});
        end
        pin_in = '0;
        cyc(3);

        // R4 level high and level low
        cfg(8'h01, 8'h00, 8'h01, 8'h00, 8'h00);
        cyc(3);
        chk("R4 idle", {31'h0, irq_o}, 32'h0);
        pin_in[0] = 1'b1;
        cyc(3);
        rchk("R4 high status", 8'h40, 32'h1);
        chk("R4 high irq", {31'h0, irq_o}, 32'h1);
        wr(8'h4C, 32'h1);
        rchk("R4 clear ignored", 8'h40, 32'h1);
        pin_in[0] = 1'b0;
        cyc(3);
        rchk("R4 follows pin", 8'h40, 32'h0);
        cfg(8'h02, 8'h00, 8'h00, 8'h00, 8'h00);
        cyc(1);
        rchk("R4 low active", 8'h40, 32'h2);
        pin_in[1] = 1'b1;
        cyc(3);
        chk("R4 low released", {31'h0, irq_o}, 32'h0);
        pin_in[1] = 1'b0;

        // R5 rising edge
        cfg(8'h04, 8'h04, 8'h04, 8'h00, 8'h00);
        cyc(4);
        rchk("R5 no edge", 8'h40, 32'h0);
        pin_in[2] = 1'b1;
        cyc(4);
        rchk("R5 rise latched", 8'h40, 32'h4);
        pin_in[2] = 1'b0;
        cyc(4);
        rchk("R5 holds after fall", 8'h40, 32'h4);
        wr(8'h4C, 32'hFB);
        rchk("R5 other clear bits", 8'h40, 32'h4);
        wr(8'h4C, 32'h04);
        rchk("R5 cleared", 8'h40, 32'h0);
        chk("R5 irq cleared", {31'h0, irq_o}, 32'h0);

        // R5 falling edge
        cfg(8'h08, 8'h08, 8'h00, 8'h00, 8'h00);
        pin_in[3] = 1'b1;
        cyc(4);
        rchk("R5 rise ignored", 8'h40, 32'h0);
        pin_in[3] = 1'b0;
        cyc(4);
        rchk("R5 fall latched", 8'h40, 32'h8);
        wr(8'h4C, 32'h08);
        rchk("R5 fall cleared", 8'h40, 32'h0);

        // R6 disable drops latch
        cfg(8'h04, 8'h04, 8'h04, 8'h00, 8'h00);
        pin_in[2] = 1'b1;
        cyc(4);
        pin_in[2] = 1'b0;
        rchk("R6 latched first", 8'h44, 32'h4);
        wr(8'h30, 32'h0);
        rchk("R6 disabled raw", 8'h44, 32'h0);
        chk("R6 disabled irq", {31'h0, irq_o}, 32'h0);
        wr(8'h30, 32'h4);
        cyc(1);
        rchk("R6 latch dropped", 8'h44, 32'h0);

        // R7 mask
        cfg(8'h01, 8'h00, 8'h01, 8'h01, 8'h00);
        pin_in[0] = 1'b1;
        cyc(3);
        rchk("R7 raw shows", 8'h44, 32'h1);
        rchk("R7 status hidden", 8'h40, 32'h0);
        chk("R7 irq hidden", {31'h0, irq_o}, 32'h0);
        wr(8'h34, 32'h0);
        chk("R7 unmasked irq", {31'h0, irq_o}, 32'h1);
        pin_in[0] = 1'b0;
        cyc(3);

        // R8 OR of sources
        cfg(8'h11, 8'h00, 8'h11, 8'h00, 8'h00);
        pin_in[0] = 1'b1; pin_in[4] = 1'b1;
        cyc(3);
        rchk("R8 two sources", 8'h40, 32'h11);
        pin_in[0] = 1'b0;
        cyc(3);
        chk("R8 one source irq", {31'h0, irq_o}, 32'h1);
        pin_in[4] = 1'b0;
        cyc(3);
        chk("R8 none irq", {31'h0, irq_o}, 32'h0);

        // R11 upper ports never interrupt
        cfg(8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00);
        cyc(3);
        pin_in[31:8] = 24'hFF_FFFF;
        cyc(4);
        chk("R11 irq", {31'h0, irq_o}, 32'h0);
        rchk("R11 raw", 8'h44, 32'h0);
        pin_in = '0;
        cyc(3);

        // R10 synchroniser stage selection
        cfg(8'h01, 8'h00, 8'h01, 8'h00, 8'h00);
        cyc(3);
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk("R10 sync one clock", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R10 sync two clocks", {31'h0, irq_o}, 32'h1);
        pin_in[0] = 1'b0;
        cyc(3);
        wr(8'h60, 32'h0);
        rchk("R10 select readback", 8'h60, 32'h0);
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk("R10 first stage one clock", {31'h0, irq_o}, 32'h1);
        pin_in[0] = 1'b0;
        cyc(3);
        wr(8'h60, 32'h1);

        // R9 debounce
        cfg(8'h01, 8'h00, 8'h01, 8'h00, 8'h01);
        cyc(30);
        chk("R9 settled low", {31'h0, irq_o}, 32'h0);
        pin_in[0] = 1'b1;
        cyc(2);
        pin_in[0] = 1'b0;
        hi_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (irq_o) hi_cnt++;
        end
        chk("R9 glitch blocked", 32'(hi_cnt), 32'h0);
        pin_in[0] = 1'b1;
        cyc(8);
        chk("R9 not yet", {31'h0, irq_o}, 32'h0);
        cyc(32);
        chk("R9 passed", {31'h0, irq_o}, 32'h1);
        pin_in[0] = 1'b0;
        cyc(40);
        wr(8'h48, 32'h0);

        // R4 and R8 random level configurations
        for (int k = 0; k < 30; k++) begin
            logic [7:0] en, pol, msk, pins, raw_e;
            en = 8'($urandom); pol = 8'($urandom); msk = 8'($urandom); pins = 8'($urandom);
            pin_in[7:0] = pins;
            cfg(en, 8'h00, pol, msk, 8'h00);
            cyc(3);
            raw_e = lvl_raw(en, pol, pins);
            rchk("R4 rand raw", 8'h44, {24'h0, raw_e});
            rchk("R7 rand status", 8'h40, {24'h0, raw_e & ~msk});
            chk("R8 rand irq", {31'h0, irq_o}, {31'h0, |(raw_e & ~msk)});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule